// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is a presettable binary counter stage with a programmable width (four bits by default). On each rising clock edge it either takes a parallel value, steps up by one, steps down by one, or keeps its value. Its state is one bank of flops driven by a single clock, so every count bit changes on the same edge.

Two active-low enables gate counting. The first, `cnt_en_n`, only gates the count. The second, `chain_en_n`, gates the count and also the carry output. The active-low terminal-count output `tc_n` follows the direction. When counting up it goes low at all ones, and when counting down it goes low at all zeros. It goes low only while `chain_en_n` is low.

To build a wider counter, connect each stage's `tc_n` to the `chain_en_n` of the next stage. All stages share the clock, the reset, `cnt_en_n`, `load_n` and `up`. Control inputs act only at the clock edge, so they may change at any point in the clock period.

Top module: `casc_updown_ctr`

## Requirements
- R1: A high `rst` at a rising edge clears `count` to 0 after that edge. This takes priority over loading and counting.
- R2: With `rst` low and `load_n` low, `count` equals `din` after the next rising edge, whatever the levels of `cnt_en_n`, `chain_en_n` and `up`.
- R3: With `load_n` high, `cnt_en_n` low, `chain_en_n` low and `up` high, `count` increases by one at each rising edge, and 15 wraps to 0.
- R4: With `load_n` high, both enables low and `up` low, `count` decreases by one at each rising edge, and 0 wraps to 15.
- R5: With `load_n` high and either enable high, `count` keeps its value across the edge.
- R6: `tc_n` is combinational. It is 0 exactly when `chain_en_n` is 0 and either `up` is 1 with `count` equal to 15, or `up` is 0 with `count` equal to 0. Otherwise it is 1, and `cnt_en_n` has no effect on it.
- R7: Changes on `load_n`, `din`, `cnt_en_n`, `chain_en_n` or `up` between rising edges leave `count` unchanged until the next rising edge.
- R8: Two stages form an 8-bit counter with the low stage's `tc_n` driving the high stage's `chain_en_n`. This counter loads, counts up, counts down and holds as one 8-bit binary counter that wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears the count |
| cnt_en_n | input | 1 | Active-low count enable, gates counting only |
| chain_en_n | input | 1 | Active-low count enable that also gates `tc_n` |
| load_n | input | 1 | Active-low synchronous parallel load |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Parallel load value |
| count | output | WIDTH | Registered count |
| tc_n | output | 1 | Active-low terminal-count output for cascading |

## Verification
The hardest case to reach is a carry from the low stage into the high stage of a chain. It needs the low stage at its terminal value in the current direction, the chain enable low and the shared enable low, all in the same cycle. It also has to be seen in both directions and together with holds. The bench first sweeps every start value of a single stage through every enable pair and both directions. It then loads the 8-bit chain just below a nibble boundary and runs it for hundreds of cycles up and then down. During these runs it drops the shared enable and the low stage's chain enable at irregular steps, and it compares every cycle against an 8-bit reference count.

// File: rtl/casc_ctr_pkg.sv
package casc_ctr_pkg;
  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_LOAD = 2'd1,
    CTR_INC  = 2'd2,
    CTR_DEC  = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/casc_ctr_mode.sv
module casc_ctr_mode
  import casc_ctr_pkg::*;
(
  input  logic    cnt_en_n,
  input  logic    chain_en_n,
  input  logic    load_n,
  input  logic    up,
  output ctr_op_e op
);
  always_comb begin
    if (!load_n)                       op = CTR_LOAD;
    else if (!cnt_en_n && !chain_en_n) op = up ? CTR_INC : CTR_DEC;
    else                               op = CTR_HOLD;
  end
endmodule

// File: rtl/casc_ctr_next.sv
module casc_ctr_next
  import casc_ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam int RUNW = WIDTH + 1;

  // run[i]: every bit below i sits at the value that makes bit i flip
  // (all ones when incrementing, all zeros when decrementing).
  logic [RUNW-1:0]  run;
  logic [WIDTH-1:0] stepped;
  logic             dir_up;

  assign dir_up = (op == CTR_INC);
  assign run[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign run[i+1]   = run[i] & (dir_up ? q[i] : ~q[i]);
    assign stepped[i] = q[i] ^ run[i];
  end

  always_comb begin
    unique case (op)
      CTR_LOAD:         nxt = din;
      CTR_INC, CTR_DEC: nxt = stepped;
      default:          nxt = q;
    endcase
  end
endmodule

// File: rtl/casc_ctr_tc.sv
module casc_ctr_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             chain_en_n,
  input  logic             up,
  output logic             tc_n
);
  logic at_top;
  logic at_bottom;

  assign at_top    = &q;
  assign at_bottom = ~|q;
  assign tc_n      = ~(~chain_en_n & (up ? at_top : at_bottom));
endmodule

// File: rtl/casc_updown_ctr.sv
module casc_updown_ctr
  import casc_ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en_n,
  input  logic             chain_en_n,
  input  logic             load_n,
  input  logic             up,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             tc_n
);
  ctr_op_e          op;
  logic [WIDTH-1:0] nxt;

  casc_ctr_mode u_mode (
    .cnt_en_n  (cnt_en_n),
    .chain_en_n(chain_en_n),
    .load_n    (load_n),
    .up        (up),
    .op        (op)
  );

  casc_ctr_next #(.WIDTH(WIDTH)) u_next (
    .op (op),
    .q  (count),
    .din(din),
    .nxt(nxt)
  );

  casc_ctr_tc #(.WIDTH(WIDTH)) u_tc (
    .q         (count),
    .chain_en_n(chain_en_n),
    .up        (up),
    .tc_n      (tc_n)
  );

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= nxt;
  end
endmodule

// File: rtl/casc_updown_ctr_chk.sv
module casc_updown_ctr_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en_n,
  input logic             chain_en_n,
  input logic             load_n,
  input logic             up,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] count,
  input logic             tc_n
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // R2
  load_takes_din_chk: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> count == $past(din));

  // R3
  count_up_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !cnt_en_n && !chain_en_n && up) |=> count == $past(count) + ONE);

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !cnt_en_n && !chain_en_n && !up) |=> count == $past(count) - ONE);

  // R5
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && (cnt_en_n || chain_en_n)) |=> $stable(count));

  // R6
  tc_needs_chain_chk: assert property (@(posedge clk) disable iff (rst)
    !tc_n |-> !chain_en_n);

  // R6
  tc_at_terminal_chk: assert property (@(posedge clk) disable iff (rst)
    !tc_n |-> (up ? (count == '1) : (count == '0)));
endmodule

bind casc_updown_ctr casc_updown_ctr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_en_n  (cnt_en_n),
  .chain_en_n(chain_en_n),
  .load_n    (load_n),
  .up        (up),
  .din       (din),
  .count     (count),
  .tc_n      (tc_n)
);

// File: tb/casc_updown_ctr_bench.sv
module casc_updown_ctr_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst, p_n, t_n, ld_n, up;
  logic [W-1:0] din_lo, din_hi, q_lo, q_hi;
  logic         c_lo, c_hi;
  int           checks = 0;
  int           fails = 0;

  casc_updown_ctr #(.WIDTH(W)) u_casc_updown_ctr (
    .clk(clk), .rst(rst), .cnt_en_n(p_n), .chain_en_n(t_n), .load_n(ld_n),
    .up(up), .din(din_lo), .count(q_lo), .tc_n(c_lo)
  );

  casc_updown_ctr #(.WIDTH(W)) u_stage_hi (
    .clk(clk), .rst(rst), .cnt_en_n(p_n), .chain_en_n(c_lo), .load_n(ld_n),
    .up(up), .din(din_hi), .count(q_hi), .tc_n(c_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] ref8;
    logic [3:0] exp4;

    rst = 1'b1; p_n = 1'b0; t_n = 1'b0; ld_n = 1'b0; up = 1'b1;
    din_lo = 4'd9; din_hi = 4'd6;
    cyc();
    // R1: reset wins over a pending load
    chk("R1 reset lo", 32'(q_lo), 0);
    chk("R1 reset hi", 32'(q_hi), 0);
    @(negedge clk);
    rst = 1'b0;

    // Single-stage sweep: every start value, direction and enable pair
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int e = 0; e < 4; e++) begin
          @(negedge clk);
          ld_n = 1'b0; din_lo = 4'(s); din_hi = 4'(15 - s);
          p_n = e[0]; t_n = e[1]; up = ~d[0];
          cyc();
          chk("R2 load", 32'(q_lo), 32'(s));
          @(negedge clk);
          ld_n = 1'b1; up = d[0]; p_n = e[0]; t_n = e[1];
          #1;
          // R6: low only with chain enable low at the directional terminal
          chk("R6 tc_n", 32'(c_lo),
              32'(!((e[1] == 1'b0) && (d[0] ? (s == 15) : (s == 0)))));
          if (e != 0)        exp4 = 4'(s);
          else if (d[0])     exp4 = 4'(s + 1);
          else               exp4 = 4'(s - 1);
          cyc();
          if (e != 0)        chk("R5 hold", 32'(q_lo), 32'(exp4));
          else if (d[0])     chk("R3 up step", 32'(q_lo), 32'(exp4));
          else               chk("R4 down step", 32'(q_lo), 32'(exp4));
        end
      end
    end

    // R7: mid-cycle control activity has no effect before the edge
    @(negedge clk);
    ld_n = 1'b0; din_lo = 4'd5; din_hi = 4'd0; p_n = 1'b1; t_n = 1'b1;
    cyc();
    @(negedge clk);
    ld_n = 1'b1;
    cyc();
    #3;
    ld_n = 1'b0; din_lo = 4'd12;
    #4;
    chk("R7 load glitch", 32'(q_lo), 5);
    p_n = 1'b0; t_n = 1'b0; up = 1'b1;
    #3;
    chk("R7 enable glitch", 32'(q_lo), 5);
    ld_n = 1'b1; p_n = 1'b1; t_n = 1'b1;
    cyc();
    chk("R7 after edge", 32'(q_lo), 5);

    // R8: 8-bit chain counting up with holds
    @(negedge clk);
    ld_n = 1'b0; din_hi = 4'hE; din_lo = 4'hA; p_n = 1'b0; t_n = 1'b0; up = 1'b1;
    cyc();
    ref8 = 8'hEA;
    chk("R8 chain load", 32'({q_hi, q_lo}), 32'(ref8));
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      ld_n = 1'b1; up = 1'b1;
      p_n = ((i % 7) == 3);
      t_n = ((i % 13) == 8);
      if (!p_n && !t_n) ref8 = ref8 + 8'd1;
      cyc();
      chk("R8 chain up", 32'({q_hi, q_lo}), 32'(ref8));
    end

    // R8: 8-bit chain counting down with holds
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      ld_n = 1'b1; up = 1'b0;
      p_n = ((i % 9) == 4);
      t_n = ((i % 11) == 5);
      if (!p_n && !t_n) ref8 = ref8 - 8'd1;
      cyc();
      chk("R8 chain down", 32'({q_hi, q_lo}), 32'(ref8));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule